// File: doc/BRIEF.md
# Character LCD Parallel Host Port

This block is the side of a character LCD controller that faces the microcontroller. The host drives an enable strobe, a register-select line, a read/write line and eight data lines. The port samples these lines into the controller clock domain and treats the falling edge of the strobe as the moment a transfer takes effect. A write with register-select low becomes a load of the instruction register. A write with register-select high becomes a load of the data register. A read with register-select high fetches display data, and a read with register-select low returns the busy flag together with the current address counter. The address counter and read data come from the controller core.

The bus can be eight lines wide or four lines wide. In the narrow case every byte is moved in two strobes on the upper four lines, most significant nibble first. The port always comes out of reset in eight-line mode, and the width is changed by a width-setting instruction. A four-line host therefore has its first width instruction taken as one whole byte, with the unused lower lines reading high. That byte still selects four-line mode, so the host only has to repeat the instruction as two nibbles. Instruction execution time is modelled by a busy counter. While it runs, new work is refused.

Top module: `lcdc_host_port`

## Requirements
- R1: After reset the port is in eight-line mode, no load or fetch pulse is issued, `hb_oe` is low, and the busy flag stays 1 for INIT_CYCLES clock cycles.
- R2: An eight-line write with `hb_rs`=0 produces a one-cycle `ir_load` pulse carrying the byte, two clock cycles after the strobe falls. At most one of `ir_load`, `dr_load`, `dr_fetch` is high in any cycle.
- R3: A write with `hb_rs`=1 produces a one-cycle `dr_load` pulse carrying the byte.
- R4: While the strobe is high with `hb_rw`=1 and `hb_rs`=0, `hb_dout` shows the busy flag on bit 7 and `core_ac` on bits 6..0, and `hb_oe` is high. `hb_oe` is low unless a read strobe is in progress.
- R5: While a read strobe with `hb_rs`=1 is high, `hb_dout` shows `core_rdata`. When the transfer completes, a one-cycle `dr_fetch` pulse is issued.
- R6: Each accepted instruction write, data write or data read sets the busy flag for EXEC_CYCLES cycles. Any transfer other than a status read that completes while the flag is 1 is ignored, with no pulse. A status read is always served.
- R7: An accepted instruction whose bits 7..5 are 001 is a width command: bit 4 = 1 selects eight lines and bit 4 = 0 selects four lines, starting with the next strobe.
- R8: In four-line mode a byte takes two strobes: the first supplies bits 7..4 and the second bits 3..0, both on `hb_din[7:4]`. `hb_din[3:0]` is ignored, and no pulse is issued after the first strobe.
- R9: A four-line read presents bits 7..4 of the read value on `hb_dout[7:4]` during the first strobe and bits 3..0 during the second, with `hb_dout[3:0]` at 0.
- R10: A change of width returns the nibble phase to the first nibble. A single eight-line strobe of 0x2F (a four-line host's width command with its low lines pulled high) loads 0x2F and switches to four-line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_en | input | 1 | Host enable strobe; transfers take effect on its falling edge |
| hb_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| hb_rw | input | 1 | 1 read, 0 write |
| hb_din | input | 8 | Host data lines into the port |
| hb_dout | output | 8 | Data presented to the host during reads |
| hb_oe | output | 1 | High while the port drives the data lines |
| core_ac | input | 7 | Address counter from the controller core |
| core_rdata | input | 8 | Display data from the controller core |
| ir_load | output | 1 | One-cycle instruction register load |
| ir_value | output | 8 | Instruction byte |
| dr_load | output | 1 | One-cycle data register load |
| dr_value | output | 8 | Data byte |
| dr_fetch | output | 1 | One-cycle data read request |

## Verification
The checker watches every cycle for the following properties:
- the three request pulses stay mutually exclusive;
- no pulse follows a cycle in which the busy counter was non-zero;
- every pulse restarts the counter at its full execution length;
- the output enable only follows a read strobe;
- the nibble phase sits at the first nibble whenever the width changes or the bus is eight lines wide.

The bench scenarios are needed for the rest: that nibbles are joined in the right order, that the low lines are ignored, the four-line host's recovery from its first width byte, read values nibble by nibble, and that transfers issued during the initial and per-instruction busy windows leave no trace.

// File: rtl/lcdc_host_pkg.sv
package lcdc_host_pkg;

    localparam int BUS_W = 8;
    localparam int NIB_W = BUS_W / 2;
    localparam int AC_W  = BUS_W - 1;

    // Instruction tag (bits 7..5) of the width command, and the bit choosing the width
    localparam logic [2:0] WIDTH_CMD_TAG = 3'b001;
    localparam int         WIDTH_BIT     = 4;

    typedef enum logic {
        WIDTH_8 = 1'b0,
        WIDTH_4 = 1'b1
    } bus_width_e;

    typedef enum logic {
        NIB_HI = 1'b0,
        NIB_LO = 1'b1
    } nib_phase_e;

    // Host lines as seen in the clock domain
    typedef struct packed {
        logic             sel_data;
        logic             is_read;
        logic [BUS_W-1:0] bits;
    } bus_sample_t;

    // A finished byte transfer
    typedef struct packed {
        logic             done;
        logic             sel_data;
        logic             is_read;
        logic [BUS_W-1:0] octet;
    } xfer_t;

    function automatic logic is_width_cmd(input logic [BUS_W-1:0] b);
        return b[BUS_W-1:BUS_W-3] == WIDTH_CMD_TAG;
    endfunction

    function automatic bus_width_e width_of_cmd(input logic [BUS_W-1:0] b);
        return b[WIDTH_BIT] ? WIDTH_8 : WIDTH_4;
    endfunction

    // Place a read value on the bus for the current width and nibble phase
    function automatic logic [BUS_W-1:0] present_read(
        input logic [BUS_W-1:0] v,
        input bus_width_e       w,
        input nib_phase_e       p
    );
        logic [NIB_W-1:0] nib;
        if (w == WIDTH_8) begin
            return v;
        end
        nib = (p == NIB_HI) ? v[BUS_W-1:NIB_W] : v[NIB_W-1:0];
        return {nib, {NIB_W{1'b0}}};
    endfunction

endpackage

// File: rtl/lcdc_strobe_sync.sv
module lcdc_strobe_sync
    import lcdc_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_pin,
    input  logic             rs_pin,
    input  logic             rw_pin,
    input  logic [BUS_W-1:0] db_pin,
    output logic             en_now,
    output bus_sample_t      samp,
    output logic             fall
);

    logic en_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_now  <= 1'b0;
            en_prev <= 1'b0;
            samp    <= '0;
        end else begin
            en_now  <= en_pin;
            en_prev <= en_now;
            samp    <= '{sel_data: rs_pin, is_read: rw_pin, bits: db_pin};
        end
    end

    // One-cycle event when the sampled strobe goes from high to low
    assign fall = en_prev & ~en_now;

endmodule

// File: rtl/lcdc_nibble_join.sv
module lcdc_nibble_join
    import lcdc_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fall,
    input  bus_sample_t samp,
    input  bus_width_e  width,
    input  logic        width_reset,
    output xfer_t       xfer,
    output nib_phase_e  phase
);

    logic [NIB_W-1:0] hi_q;

    always_comb begin
        xfer = '0;
        if (fall) begin
            if (width == WIDTH_8) begin
                xfer = '{done: 1'b1, sel_data: samp.sel_data,
                         is_read: samp.is_read, octet: samp.bits};
            end else if (phase == NIB_LO) begin
                xfer = '{done: 1'b1, sel_data: samp.sel_data,
                         is_read: samp.is_read,
                         octet: {hi_q, samp.bits[BUS_W-1:NIB_W]}};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= NIB_HI;
            hi_q  <= '0;
        end else if (width_reset) begin
            phase <= NIB_HI;
        end else if (fall && width == WIDTH_4) begin
            if (phase == NIB_HI) begin
                hi_q  <= samp.bits[BUS_W-1:NIB_W];
                phase <= NIB_LO;
            end else begin
                phase <= NIB_HI;
            end
        end
    end

endmodule

// File: rtl/lcdc_busy_timer.sv
module lcdc_busy_timer #(
    parameter int INIT_CYCLES = 400,
    parameter int EXEC_CYCLES = 40,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    output logic             busy,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] INIT_VAL = CNT_W'(INIT_CYCLES);
    localparam logic [CNT_W-1:0] EXEC_VAL = CNT_W'(EXEC_CYCLES);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= INIT_VAL;
        end else if (load) begin
            count <= EXEC_VAL;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign busy = (count != '0);

endmodule

// File: rtl/lcdc_host_port.sv
module lcdc_host_port
    import lcdc_host_pkg::*;
#(
    parameter int INIT_CYCLES = 400,
    parameter int EXEC_CYCLES = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hb_en,
    input  logic             hb_rs,
    input  logic             hb_rw,
    input  logic [BUS_W-1:0] hb_din,
    output logic [BUS_W-1:0] hb_dout,
    output logic             hb_oe,
    input  logic [AC_W-1:0]  core_ac,
    input  logic [BUS_W-1:0] core_rdata,
    output logic             ir_load,
    output logic [BUS_W-1:0] ir_value,
    output logic             dr_load,
    output logic [BUS_W-1:0] dr_value,
    output logic             dr_fetch
);

    localparam int CNT_MAX = (INIT_CYCLES > EXEC_CYCLES) ? INIT_CYCLES : EXEC_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             en_now;
    bus_sample_t      samp;
    logic             fall;
    xfer_t            xfer;
    nib_phase_e       phase;
    bus_width_e       width_q;
    logic             width_reset;
    logic             busy;
    logic [CNT_W-1:0] busy_cnt;
    logic             is_status;
    logic             accept;
    logic             acc_ir;
    logic [BUS_W-1:0] read_src;

    lcdc_strobe_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .en_pin (hb_en),
        .rs_pin (hb_rs),
        .rw_pin (hb_rw),
        .db_pin (hb_din),
        .en_now (en_now),
        .samp   (samp),
        .fall   (fall)
    );

    lcdc_nibble_join u_join (
        .clk         (clk),
        .rst         (rst),
        .fall        (fall),
        .samp        (samp),
        .width       (width_q),
        .width_reset (width_reset),
        .xfer        (xfer),
        .phase       (phase)
    );

    lcdc_busy_timer #(
        .INIT_CYCLES (INIT_CYCLES),
        .EXEC_CYCLES (EXEC_CYCLES),
        .CNT_W       (CNT_W)
    ) u_busy (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .busy  (busy),
        .count (busy_cnt)
    );

    // Status reads bypass the busy check; everything else must wait
    assign is_status   = xfer.done & ~xfer.sel_data & xfer.is_read;
    assign accept      = xfer.done & ~is_status & ~busy;
    assign acc_ir      = accept & ~xfer.sel_data & ~xfer.is_read;
    assign width_reset = acc_ir & is_width_cmd(xfer.octet)
                       & (width_of_cmd(xfer.octet) != width_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q <= WIDTH_8;
        end else if (width_reset) begin
            width_q <= width_of_cmd(xfer.octet);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_load  <= 1'b0;
            ir_value <= '0;
            dr_load  <= 1'b0;
            dr_value <= '0;
            dr_fetch <= 1'b0;
        end else begin
            ir_load  <= acc_ir;
            dr_load  <= accept & xfer.sel_data & ~xfer.is_read;
            dr_fetch <= accept & xfer.sel_data & xfer.is_read;
            if (acc_ir) begin
                ir_value <= xfer.octet;
            end
            if (accept && xfer.sel_data && !xfer.is_read) begin
                dr_value <= xfer.octet;
            end
        end
    end

    assign read_src = samp.sel_data ? core_rdata : {busy, core_ac};
    assign hb_oe    = en_now & samp.is_read;
    assign hb_dout  = hb_oe ? present_read(read_src, width_q, phase) : '0;

endmodule

// File: rtl/lcdc_host_port_chk.sv
module lcdc_host_port_chk #(
    parameter int EXEC_CYCLES = 40,
    parameter int CNT_W       = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             hb_en,
    input logic             hb_rw,
    input logic             hb_oe,
    input logic             ir_load,
    input logic             dr_load,
    input logic             dr_fetch,
    input logic [CNT_W-1:0] busy_cnt,
    input logic             width_q,
    input logic             phase
);

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ir_load, dr_load, dr_fetch})); // R2

    AST_REQ_RESTARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ir_load || dr_load || dr_fetch) |-> busy_cnt == CNT_W'(EXEC_CYCLES)); // R6

    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ir_load || dr_load || dr_fetch) |-> $past(busy_cnt) == '0); // R6

    AST_OE_AFTER_READ_STROBE: assert property (@(posedge clk) disable iff (rst)
        hb_oe |-> ($past(hb_en) && $past(hb_rw))); // R4

    AST_PHASE_ON_WIDTH_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(width_q) |-> phase == 1'b0); // R10

    AST_WIDE_SINGLE_PHASE: assert property (@(posedge clk) disable iff (rst)
        (width_q == 1'b0) |-> phase == 1'b0); // R8

endmodule

bind lcdc_host_port lcdc_host_port_chk #(
    .EXEC_CYCLES (EXEC_CYCLES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hb_en    (hb_en),
    .hb_rw    (hb_rw),
    .hb_oe    (hb_oe),
    .ir_load  (ir_load),
    .dr_load  (dr_load),
    .dr_fetch (dr_fetch),
    .busy_cnt (busy_cnt),
    .width_q  (width_q),
    .phase    (phase)
);

// File: tb/lcdc_host_port_test.sv
module lcdc_host_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int INIT_CYC   = 400;
    localparam int EXEC_CYC   = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hb_en = 1'b0, hb_rs = 1'b0, hb_rw = 1'b0;
    logic [7:0] hb_din = 8'h00;
    logic [7:0] hb_dout;
    logic       hb_oe;
    logic [6:0] core_ac = 7'h00;
    logic [7:0] core_rdata = 8'h00;
    logic       ir_load, dr_load, dr_fetch;
    logic [7:0] ir_value, dr_value;

    int n_chk = 0, n_err = 0;
    int n_ir = 0, n_dr = 0, n_rd = 0;
    logic [7:0] last_ir = 8'h00, last_dr = 8'h00;
    bit m_w4 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdc_host_port #(.INIT_CYCLES(INIT_CYC), .EXEC_CYCLES(EXEC_CYC)) uut (
        .clk(clk), .rst(rst), .hb_en(hb_en), .hb_rs(hb_rs), .hb_rw(hb_rw),
        .hb_din(hb_din), .hb_dout(hb_dout), .hb_oe(hb_oe),
        .core_ac(core_ac), .core_rdata(core_rdata),
        .ir_load(ir_load), .ir_value(ir_value), .dr_load(dr_load),
        .dr_value(dr_value), .dr_fetch(dr_fetch)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ir_load)  begin n_ir++; last_ir = ir_value; end
            if (dr_load)  begin n_dr++; last_dr = dr_value; end
            if (dr_fetch) n_rd++;
        end
    end

    function automatic logic [7:0] exp_status(input bit busy, input logic [6:0] ac);
        return {busy, ac};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic rs, input logic rw, input logic [7:0] d,
                          output logic [7:0] q, output logic oe);
        @(negedge clk);
        hb_rs = rs; hb_rw = rw; hb_din = d; hb_en = 1'b1;
        repeat (3) @(negedge clk);
        q = hb_dout; oe = hb_oe;
        hb_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // One byte at the current model width; low lines carry noise in 4-line mode
    task automatic xfer(input logic rs, input logic rw, input logic [7:0] b,
                        output logic [7:0] got);
        logic [7:0] q1, q2;
        logic oe;
        if (m_w4) begin
            strobe(rs, rw, {b[7:4], 4'($urandom)}, q1, oe);
            strobe(rs, rw, {b[3:0], 4'($urandom)}, q2, oe);
            check("R9 low lines zero", {q1[3:0], q2[3:0]}, rw ? 8'h00 : 8'h00);
            got = {q1[7:4], q2[7:4]};
        end else begin
            strobe(rs, rw, b, got, oe);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] got, q;
        logic oe;
        int b_ir, b_dr, b_rd;
        int unused_seed;
        unused_seed = $urandom(32'h5EED1);

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 oe idle", hb_oe, 1'b0);
        check("R1 no pulses", n_ir + n_dr + n_rd, 0);

        // R1/R4: status read during initialisation shows busy
        core_ac = 7'h15;
        xfer(1'b0, 1'b1, 8'h00, got);
        check("R1 R4 status busy", got, exp_status(1'b1, 7'h15));
        // R6: write during init ignored
        xfer(1'b0, 1'b0, 8'h01, got);
        check("R6 write in init ignored", n_ir, 0);
        idle(INIT_CYC + 20);
        xfer(1'b0, 1'b1, 8'h00, got);
        check("R1 busy cleared", got, exp_status(1'b0, 7'h15));

        // R2: instruction write
        xfer(1'b0, 1'b0, 8'h0C, got);
        check("R2 ir count", n_ir, 1);
        check("R2 ir value", last_ir, 8'h0C);
        // R6: busy right after, data write ignored, status served
        xfer(1'b0, 1'b1, 8'h00, got);
        check("R6 status busy", got[7], 1'b1);
        xfer(1'b1, 1'b0, 8'h55, got);
        check("R6 data write ignored", n_dr, 0);
        idle(EXEC_CYC + 5);

        // R3: data write
        xfer(1'b1, 1'b0, 8'hA5, got);
        check("R3 dr count", n_dr, 1);
        check("R3 dr value", last_dr, 8'hA5);
        idle(EXEC_CYC + 5);
        // R5: data read
        core_rdata = 8'h3C;
        xfer(1'b1, 1'b1, 8'h00, got);
        check("R5 read value", got, 8'h3C);
        check("R5 fetch pulse", n_rd, 1);
        idle(EXEC_CYC + 5);

        // R10: four-line host's first width command arrives as one byte
        xfer(1'b0, 1'b0, 8'h2F, got);
        check("R10 byte latched", last_ir, 8'h2F);
        check("R10 forced bits set", last_ir[2:0], 3'b111);
        m_w4 = 1'b1;
        idle(EXEC_CYC + 5);

        // R8: nibble assembly, no pulse after first nibble
        b_ir = n_ir;
        strobe(1'b0, 1'b0, 8'h2F, q, oe);
        check("R8 no pulse after first nibble", n_ir, b_ir);
        strobe(1'b0, 1'b0, 8'h83, q, oe);
        check("R8 joined byte", last_ir, 8'h28);
        check("R8 one pulse", n_ir, b_ir + 1);
        idle(EXEC_CYC + 5);

        // R9: four-line status and data read
        core_ac = 7'h5A;
        xfer(1'b0, 1'b1, 8'h00, got);
        check("R9 status nibbles", got, exp_status(1'b0, 7'h5A));
        core_rdata = 8'hE7;
        xfer(1'b1, 1'b1, 8'h00, got);
        check("R9 data nibbles", got, 8'hE7);
        idle(EXEC_CYC + 5);

        // R7: back to eight lines, then single-strobe write
        xfer(1'b0, 1'b0, 8'h30, got);
        check("R7 width cmd", last_ir, 8'h30);
        m_w4 = 1'b0;
        idle(EXEC_CYC + 5);
        b_ir = n_ir;
        xfer(1'b0, 1'b0, 8'h80, got);
        check("R7 eight-line write", last_ir, 8'h80);
        check("R7 single pulse", n_ir, b_ir + 1);
        idle(EXEC_CYC + 5);

        // Random mix across both widths
        for (int i = 0; i < 60; i++) begin
            int kind;
            logic [7:0] b;
            kind = int'($urandom % 4);
            b = 8'($urandom);
            core_ac = 7'($urandom);
            core_rdata = 8'($urandom);
            b_ir = n_ir; b_dr = n_dr; b_rd = n_rd;
            case (kind)
                0: begin
                    xfer(1'b0, 1'b0, b, got);
                    check("R2 random ir", last_ir, b);
                    check("R2 random ir count", n_ir, b_ir + 1);
                    if (b[7:5] == 3'b001) m_w4 = ~b[4]; // R7
                end
                1: begin
                    xfer(1'b1, 1'b0, b, got);
                    check("R3 random dr", last_dr, b);
                    check("R3 random dr count", n_dr, b_dr + 1);
                end
                2: begin
                    xfer(1'b1, 1'b1, b, got);
                    check("R5 random read", got, core_rdata);
                    check("R5 random fetch", n_rd, b_rd + 1);
                end
                default: begin
                    xfer(1'b0, 1'b1, b, got);
                    check("R4 random status", got, exp_status(1'b0, core_ac));
                    check("R4 status no pulse", n_ir + n_dr + n_rd, b_ir + b_dr + b_rd);
                end
            endcase
            idle(EXEC_CYC + 5);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule